// File: doc/BRIEF.md
# Cache Way Shrink Controller

This controller decides how many ways of a 16-way last-level cache take part in allocation. A smaller active array holds fewer marginal bit cells, so the shared supply can sit roughly 30 mV lower while the load is light. An activity monitor delivers periodic samples. When enough consecutive samples fall below a low threshold, the controller retires ways 2 to 15. Each of these ways is first removed from allocation, then flushed through a per-way request/acknowledge handshake, and only then put to sleep. Ways 0 and 1 stay in service at all times.

When enough consecutive samples rise above a high threshold, the controller wakes the sleeping ways one at a time in ascending order. Each way gets a programmable settle interval before it returns to the allocation mask. A shrink or an expansion always runs to its end before the opposite request is acted on. A 2-bit status output reports the current phase. The cache arrays and the flush engine sit outside this block.

Top module: `llc_way_shrink_ctrl`

## Requirements
- R1: After reset the status is full (code 0), `alloc_mask` is all ones, and `way_sleep` and `flush_req` are all zeros.
- R2: A shrink starts only after `dwell_samples` consecutive valid samples (`sample_valid` high) with `activity_level` strictly below `low_thresh`. Any valid sample not below that threshold restarts the count. Cycles with `sample_valid` low neither count nor restart it. The status changes to flushing one cycle after the clock edge that registers the qualifying sample.
- R3: An expansion starts only from the shrunk state, after `dwell_samples` consecutive valid samples strictly above `high_thresh`. While the status is full, high samples change nothing.
- R4: Ways 2 to 15 are retired one at a time in ascending order. A way's `alloc_mask` bit clears one cycle before its `flush_req` bit rises, and at most one `flush_req` bit is high at any time.
- R5: `flush_req` holds until the matching `flush_ack` bit is seen at a clock edge. At that edge the way's `way_sleep` bit sets and the request drops. An acknowledge on a way that has no request pending has no effect.
- R6: Once way 15 is acknowledged, the status becomes shrunk (code 2) with `alloc_mask` = 0x0003 and `way_sleep` = 0xFFFC. Ways 0 and 1 are never removed from allocation and never put to sleep.
- R7: During waking (code 3), a way's `way_sleep` bit clears first. Its `alloc_mask` bit returns `settle_cycles`+1 cycles later. The next way's sleep bit is released at that same edge. Once way 15 returns, the status goes back to full.
- R8: Samples that meet the opposite condition during flushing (code 1) or waking are still counted but do not interrupt the sequence. If the count is met when the sequence finishes, the opposite transition starts on the next cycle.
- R9: The status encoding is full = 0, flushing = 1, shrunk = 2, waking = 3.
- R10: A `dwell_samples` value of 0 behaves like 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | Activity sample strobe |
| activity_level | input | 8 | Activity sample value |
| low_thresh | input | 8 | Samples below this value count toward a shrink |
| high_thresh | input | 8 | Samples above this value count toward an expansion |
| dwell_samples | input | 8 | Number of consecutive qualifying samples required |
| settle_cycles | input | 8 | Wake settle interval per way |
| flush_ack | input | 16 | Per-way flush done |
| flush_req | output | 16 | Per-way flush request |
| way_sleep | output | 16 | Per-way sleep enable |
| alloc_mask | output | 16 | Ways open for allocation |
| state_o | output | 2 | Current phase |

## Verification
A table of activity samples feeds the qualifier with several patterns: runs of low samples broken by mid-band samples, by high samples and by a sample exactly at the threshold; invalid strobes inside a run; and a clean run of three. These show whether the run counter restarts, holds or completes, and so whether a shrink starts after the right sample. Directed sequences then walk the ascending flush order with correct and stray acknowledges, which separates a correct mask-before-request order and a correct sleep-on-acknowledge rule from wrong ones. They also check the exact settle cycle at which a woken way returns. A high-activity run placed inside a flush checks that the expansion is deferred, and a zero dwell value and a reset in the middle of a flush cover the remaining corner cases.

// File: rtl/llc_shrink_pkg.sv
package llc_shrink_pkg;

    typedef enum logic [1:0] {
        ST_FULL   = 2'd0,
        ST_FLUSH  = 2'd1,
        ST_SHRUNK = 2'd2,
        ST_WAKE   = 2'd3
    } shrink_state_e;

endpackage

// File: rtl/llc_shrink_act_filter.sv
module llc_shrink_act_filter #(
    parameter int ACT_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid,
    input  logic [ACT_W-1:0] activity_level,
    input  logic [ACT_W-1:0] low_thresh,
    input  logic [ACT_W-1:0] high_thresh,
    input  logic [CNT_W-1:0] dwell_samples,
    input  logic             clear,
    output logic             low_go,
    output logic             high_go
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] low_run;
        logic [CNT_W-1:0] high_run;
    } run_t;

    run_t run_d, run_q;
    logic [CNT_W-1:0] need;

    always_comb begin
        run_d = run_q;
        if (clear) begin
            run_d.low_run  = '0;
            run_d.high_run = '0;
        end else if (sample_valid) begin
            if (activity_level < low_thresh) begin
                if (run_q.low_run != CNT_MAX) run_d.low_run = run_q.low_run + CNT_W'(1);
                run_d.high_run = '0;
            end else if (activity_level > high_thresh) begin
                if (run_q.high_run != CNT_MAX) run_d.high_run = run_q.high_run + CNT_W'(1);
                run_d.low_run = '0;
            end else begin
                run_d.low_run  = '0;
                run_d.high_run = '0;
            end
        end
        need    = (dwell_samples == '0) ? CNT_W'(1) : dwell_samples;
        low_go  = (run_q.low_run  >= need);
        high_go = (run_q.high_run >= need);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q.low_run  <= '0;
            run_q.high_run <= '0;
        end else begin
            run_q <= run_d;
        end
    end

endmodule

// File: rtl/llc_shrink_way_decode.sv
module llc_shrink_way_decode #(
    parameter int NUM_WAYS = 16,
    parameter int IDX_W    = 4
) (
    input  logic [IDX_W-1:0]    idx,
    output logic [NUM_WAYS-1:0] onehot
);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign onehot[w] = (idx == IDX_W'(w));
    end

endmodule

// File: rtl/llc_way_shrink_ctrl.sv
module llc_way_shrink_ctrl
    import llc_shrink_pkg::*;
#(
    parameter int NUM_WAYS  = 16,
    parameter int KEEP_WAYS = 2,
    parameter int ACT_W     = 8,
    parameter int CNT_W     = 8,
    parameter int SETTLE_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [ACT_W-1:0]    activity_level,
    input  logic [ACT_W-1:0]    low_thresh,
    input  logic [ACT_W-1:0]    high_thresh,
    input  logic [CNT_W-1:0]    dwell_samples,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [NUM_WAYS-1:0] flush_ack,
    output logic [NUM_WAYS-1:0] flush_req,
    output logic [NUM_WAYS-1:0] way_sleep,
    output logic [NUM_WAYS-1:0] alloc_mask,
    output logic [1:0]          state_o
);

    localparam int IDX_W = $clog2(NUM_WAYS);
    localparam logic [IDX_W-1:0] KEEP_IDX = IDX_W'(KEEP_WAYS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WAYS - 1);
    localparam logic [NUM_WAYS-1:0] FIRST_OH = NUM_WAYS'(1) << KEEP_WAYS;

    typedef struct packed {
        shrink_state_e       state;
        logic [IDX_W-1:0]    cursor;
        logic [NUM_WAYS-1:0] alloc;
        logic [NUM_WAYS-1:0] sleep;
        logic [NUM_WAYS-1:0] freq;
        logic [SETTLE_W-1:0] settle;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic clr_runs;
    logic low_go, high_go;
    logic [NUM_WAYS-1:0] cur_oh, nxt_oh;
    logic [IDX_W-1:0] nxt_idx;

    assign nxt_idx = ctl_q.cursor + IDX_W'(1);

    llc_shrink_act_filter #(.ACT_W(ACT_W), .CNT_W(CNT_W)) filt_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_valid   (sample_valid),
        .activity_level (activity_level),
        .low_thresh     (low_thresh),
        .high_thresh    (high_thresh),
        .dwell_samples  (dwell_samples),
        .clear          (clr_runs),
        .low_go         (low_go),
        .high_go        (high_go)
    );

    llc_shrink_way_decode #(.NUM_WAYS(NUM_WAYS), .IDX_W(IDX_W)) cur_dec_i (
        .idx    (ctl_q.cursor),
        .onehot (cur_oh)
    );

    llc_shrink_way_decode #(.NUM_WAYS(NUM_WAYS), .IDX_W(IDX_W)) nxt_dec_i (
        .idx    (nxt_idx),
        .onehot (nxt_oh)
    );

    always_comb begin
        ctl_d    = ctl_q;
        clr_runs = 1'b0;
        unique case (ctl_q.state)
            ST_FULL: begin
                if (low_go) begin
                    ctl_d.state  = ST_FLUSH;
                    ctl_d.cursor = KEEP_IDX;
                    ctl_d.alloc  = ctl_q.alloc & ~FIRST_OH;
                    ctl_d.freq   = '0;
                    clr_runs     = 1'b1;
                end
            end
            ST_FLUSH: begin
                if (ctl_q.freq == '0) begin
                    ctl_d.freq = cur_oh;
                end else if ((flush_ack & cur_oh) != '0) begin
                    ctl_d.freq  = '0;
                    ctl_d.sleep = ctl_q.sleep | cur_oh;
                    if (ctl_q.cursor == LAST_IDX) begin
                        ctl_d.state = ST_SHRUNK;
                    end else begin
                        ctl_d.cursor = nxt_idx;
                        ctl_d.alloc  = ctl_q.alloc & ~nxt_oh;
                    end
                end
            end
            ST_SHRUNK: begin
                if (high_go) begin
                    ctl_d.state  = ST_WAKE;
                    ctl_d.cursor = KEEP_IDX;
                    ctl_d.sleep  = ctl_q.sleep & ~FIRST_OH;
                    ctl_d.settle = settle_cycles;
                    clr_runs     = 1'b1;
                end
            end
            ST_WAKE: begin
                if (ctl_q.settle != '0) begin
                    ctl_d.settle = ctl_q.settle - SETTLE_W'(1);
                end else begin
                    ctl_d.alloc = ctl_q.alloc | cur_oh;
                    if (ctl_q.cursor == LAST_IDX) begin
                        ctl_d.state = ST_FULL;
                    end else begin
                        ctl_d.cursor = nxt_idx;
                        ctl_d.sleep  = ctl_q.sleep & ~nxt_oh;
                        ctl_d.settle = settle_cycles;
                    end
                end
            end
            default: ctl_d.state = ST_FULL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state  <= ST_FULL;
            ctl_q.cursor <= '0;
            ctl_q.alloc  <= '1;
            ctl_q.sleep  <= '0;
            ctl_q.freq   <= '0;
            ctl_q.settle <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign flush_req  = ctl_q.freq;
    assign way_sleep  = ctl_q.sleep;
    assign alloc_mask = ctl_q.alloc;
    assign state_o    = ctl_q.state;

endmodule

module llc_shrink_chk #(
    parameter int NUM_WAYS  = 16,
    parameter int KEEP_WAYS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_WAYS-1:0] flush_req,
    input logic [NUM_WAYS-1:0] flush_ack,
    input logic [NUM_WAYS-1:0] way_sleep,
    input logic [NUM_WAYS-1:0] alloc_mask,
    input logic [1:0]          state_o
);

    localparam logic [NUM_WAYS-1:0] KEEP_MASK = {NUM_WAYS{1'b1}} >> (NUM_WAYS - KEEP_WAYS);

    // R4
    flush_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_req));

    // R4
    req_unalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req & alloc_mask) == '0);

    // R7
    sleep_alloc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (way_sleep & alloc_mask) == '0);

    // R6
    keep_ways_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((alloc_mask & KEEP_MASK) == KEEP_MASK) && ((way_sleep & KEEP_MASK) == '0));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req != '0 && (flush_req & flush_ack) == '0) |=> $stable(flush_req));

    // R9
    full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |-> (alloc_mask == '1 && way_sleep == '0));

    // R6
    shrunk_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |-> (alloc_mask == KEEP_MASK && way_sleep == ~KEEP_MASK));

endmodule

bind llc_way_shrink_ctrl llc_shrink_chk #(.NUM_WAYS(NUM_WAYS), .KEEP_WAYS(KEEP_WAYS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_req  (flush_req),
    .flush_ack  (flush_ack),
    .way_sleep  (way_sleep),
    .alloc_mask (alloc_mask),
    .state_o    (state_o)
);

// File: tb/llc_way_shrink_ctrl_tb.sv
module llc_way_shrink_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [7:0]  activity_level = '0;
    logic [7:0]  low_thresh = 8'd20;
    logic [7:0]  high_thresh = 8'd200;
    logic [7:0]  dwell_samples = 8'd3;
    logic [7:0]  settle_cycles = 8'd4;
    logic [15:0] flush_ack = '0;
    logic [15:0] flush_req, way_sleep, alloc_mask;
    logic [1:0]  state_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    llc_way_shrink_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .activity_level(activity_level), .low_thresh(low_thresh),
        .high_thresh(high_thresh), .dwell_samples(dwell_samples),
        .settle_cycles(settle_cycles), .flush_ack(flush_ack),
        .flush_req(flush_req), .way_sleep(way_sleep),
        .alloc_mask(alloc_mask), .state_o(state_o)
    );

    // {valid, activity, expected status after sample plus one idle cycle}
    localparam logic [10:0] SAMPLE_VEC [13] = '{
        {1'b1, 8'd5,   2'd0}, {1'b1, 8'd5,   2'd0}, {1'b1, 8'd100, 2'd0},
        {1'b1, 8'd5,   2'd0}, {1'b0, 8'd5,   2'd0}, {1'b1, 8'd5,   2'd0},
        {1'b1, 8'd250, 2'd0}, {1'b1, 8'd5,   2'd0}, {1'b1, 8'd19,  2'd0},
        {1'b1, 8'd20,  2'd0}, {1'b1, 8'd0,   2'd0}, {1'b1, 8'd1,   2'd0},
        {1'b1, 8'd2,   2'd1}
    };

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic give_sample(logic v, logic [7:0] a);
        sample_valid   = v;
        activity_level = a;
        @(negedge clk);
        sample_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic flush_way(int w);
        int waited = 0;
        while (flush_req[w] !== 1'b1 && waited < 8) begin
            @(negedge clk);
            waited++;
        end
        chk("R4 request order", flush_req, 16'(1) << w);
        chk("R4 mask cleared before request", 16'(alloc_mask[w]), 16'h0);
        flush_ack[w] = 1'b1;
        @(negedge clk);
        flush_ack[w] = 1'b0;
        chk("R5 sleep after ack", 16'(way_sleep[w]), 16'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 status", 16'(state_o), 16'h0);
        chk("R1 alloc", alloc_mask, 16'hFFFF);
        chk("R1 sleep", way_sleep, 16'h0);
        chk("R1 req", flush_req, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 sample qualification table
        foreach (SAMPLE_VEC[k]) begin
            give_sample(SAMPLE_VEC[k][10], SAMPLE_VEC[k][9:2]);
            chk($sformatf("R2 R9 sample %0d status", k), 16'(state_o), 16'(SAMPLE_VEC[k][1:0]));
        end

        // R4 first way masked, request one cycle later
        chk("R4 mask before request", alloc_mask, 16'hFFFB);
        chk("R4 no request yet", flush_req, 16'h0);
        @(negedge clk);
        chk("R4 first request", flush_req, 16'h0004);

        // R5 stray acknowledge ignored
        flush_ack = 16'h0020;
        @(negedge clk);
        flush_ack = '0;
        chk("R5 stray ack req", flush_req, 16'h0004);
        chk("R5 stray ack sleep", way_sleep, 16'h0);

        // R8 high run during flushing is deferred
        repeat (3) give_sample(1'b1, 8'd250);
        chk("R8 still flushing", 16'(state_o), 16'h1);
        chk("R8 request held", flush_req, 16'h0004);

        for (int w = 2; w < 16; w++) flush_way(w);
        chk("R6 status shrunk", 16'(state_o), 16'h2);
        chk("R6 alloc", alloc_mask, 16'h0003);
        chk("R6 sleep", way_sleep, 16'hFFFC);

        // R8 deferred expansion starts next cycle; R7 settle timing
        @(negedge clk);
        chk("R8 waking starts", 16'(state_o), 16'h3);
        chk("R7 first wake sleep", way_sleep, 16'hFFF8);
        chk("R7 first wake alloc", alloc_mask, 16'h0003);
        repeat (4) @(negedge clk);
        chk("R7 settling alloc", alloc_mask, 16'h0003);
        @(negedge clk);
        chk("R7 way returned", alloc_mask, 16'h0007);
        chk("R7 next released", way_sleep, 16'hFFF0);
        repeat (64) @(negedge clk);
        chk("R7 still waking", 16'(state_o), 16'h3);
        @(negedge clk);
        chk("R7 full again", 16'(state_o), 16'h0);
        chk("R7 alloc full", alloc_mask, 16'hFFFF);
        chk("R7 sleep clear", way_sleep, 16'h0);

        // R3 high samples ignored while full
        repeat (4) give_sample(1'b1, 8'd250);
        chk("R3 full ignores high", 16'(state_o), 16'h0);
        chk("R3 alloc unchanged", alloc_mask, 16'hFFFF);

        // R10 dwell zero acts as one
        dwell_samples = 8'd0;
        give_sample(1'b1, 8'd3);
        chk("R10 single sample shrink", 16'(state_o), 16'h1);
        flush_way(2);
        flush_way(3);

        // R1 reset mid flush
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset status", 16'(state_o), 16'h0);
        chk("R1 reset alloc", alloc_mask, 16'hFFFF);
        chk("R1 reset sleep", way_sleep, 16'h0);
        chk("R1 reset req", flush_req, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule